// File: doc/BRIEF.md
# Power-Transition Time-Stamp Capture

This block keeps two snapshots of a running calendar clock, each taken when the chip's power source changes. One snapshot is taken when the main supply drops out and the battery takes over. The other is taken when the battery hands back to the main supply. Each snapshot holds five time fields: seconds, minutes, hours, date and month. The clock that produces these fields, and the circuits that detect the supply voltages, sit outside this block. They deliver the live fields and one-cycle transition strobes.

The two snapshots follow different policies. The battery-entry snapshot keeps the earliest transition and ignores every later one until software clears it. The supply-return snapshot is overwritten on every transition, so it always holds the latest one. A cleared snapshot is all zeros, including the date and month bytes, and a zero value means no transition has been recorded. Software reads the bytes through a small register window. Setting one bit in a control register clears both snapshots.

Top module: `pwr_tstamp_capture`

## Requirements
- R1: After a synchronous reset, both snapshots are all zeros (`rec_to_bat`, `rec_to_main` and every byte read back), and `reg_rdata` is 0.
- R2: While the battery-entry snapshot is empty (no capture since the last reset or clear), a `to_bat_stb` pulse loads the live fields at that clock edge. The values appear on `rec_to_bat` from the next cycle. Packing is seconds in bits 7:0, minutes in 15:8, hours in 23:16, date in 31:24 and month in 39:32.
- R3: Once the battery-entry snapshot holds a capture, further `to_bat_stb` pulses leave it unchanged until a clear.
- R4: Every `to_main_stb` pulse loads the live fields into the supply-return snapshot (`rec_to_main`, same packing as R2) and replaces any earlier content.
- R5: A register write to address 10 with data bit 0 set clears both snapshots to all zeros in the next cycle. It also re-arms the battery-entry snapshot, so the next `to_bat_stb` is captured again.
- R6: A write to address 10 with bit 0 at 0 changes neither snapshot.
- R7: When a clear write and either transition strobe fall in the same cycle, the clear wins and both snapshots end up all zeros. The battery-entry snapshot stays armed afterwards.
- R8: Reading address 10 returns 0. The clear bit behaves as a one-cycle pulse and never reads back as 1.
- R9: Reads have one cycle of latency: `reg_rdata` shows the byte selected by the `reg_addr` present at the previous clock edge. Addresses 0 to 4 return the battery-entry snapshot's seconds, minutes, hours, date and month. Addresses 5 to 9 return the same fields of the supply-return snapshot. Addresses 11 to 15 return 0.
- R10: A `to_bat_stb` and a `to_main_stb` in the same cycle, with the battery-entry snapshot empty, load the same live fields into both snapshots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tm_sec | input | 8 | Live seconds field |
| tm_min | input | 8 | Live minutes field |
| tm_hour | input | 8 | Live hours field |
| tm_date | input | 8 | Live day-of-month field |
| tm_month | input | 8 | Live month field |
| to_bat_stb | input | 1 | One-cycle pulse: main supply has fallen over to battery |
| to_main_stb | input | 1 | One-cycle pulse: battery has handed back to the main supply |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| rec_to_bat | output | 40 | Battery-entry snapshot, packed |
| rec_to_main | output | 40 | Supply-return snapshot, packed |

## Verification
A clear command can arrive in the same cycle as a power-transition strobe. The bench provokes this by raising the control-register write and both strobes at the same negative edge, with a distinctive non-zero time on the live fields. The result is judged at the ports: both snapshots must read back all zeros. A second battery strobe must then be captured, which shows that the clear also re-armed the first-event gate and did not leave it set by the collided strobe.

// File: rtl/pts_pkg.sv
package pts_pkg;

  // Capture policy of one snapshot record
  typedef enum logic [0:0] {
    CAP_KEEP_FIRST = 1'b0,
    CAP_KEEP_LAST  = 1'b1
  } cap_mode_e;

  // Number of time fields held per snapshot (seconds .. month)
  localparam int NUM_FIELDS = 5;

  // Field order inside a packed snapshot, lowest byte first
  typedef enum int {
    FLD_SEC   = 0,
    FLD_MIN   = 1,
    FLD_HOUR  = 2,
    FLD_DATE  = 3,
    FLD_MONTH = 4
  } field_e;

  // Bit of the control register that requests a clear
  localparam int CLR_BIT = 0;

  // Number of snapshot records
  localparam int NUM_RECS = 2;

endpackage

// File: rtl/pts_record.sv
module pts_record #(
  parameter int                  FIELD_W    = 8,
  parameter int                  NUM_FIELDS = 5,
  parameter pts_pkg::cap_mode_e  MODE       = pts_pkg::CAP_KEEP_LAST
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr,
  input  logic                          stb,
  input  logic [FIELD_W*NUM_FIELDS-1:0] live_i,
  output logic [FIELD_W*NUM_FIELDS-1:0] rec_o
);

  localparam int REC_W = FIELD_W * NUM_FIELDS;

  logic [REC_W-1:0] rec_q;
  logic             cap_en;

  generate
    if (MODE == pts_pkg::CAP_KEEP_FIRST) begin : g_first
      logic taken_q;

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          taken_q <= 1'b0;
        end else if (stb) begin
          taken_q <= 1'b1;
        end
      end

      assign cap_en = stb & ~taken_q;

      AST_FIRST_LOADS: assert property (@(posedge clk) disable iff (rst)
        (stb && !clr && !taken_q) |=> (rec_q == $past(live_i))); // R2

      AST_FIRST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (taken_q && !clr) |=> $stable(rec_q)); // R3
    end else begin : g_last
      assign cap_en = stb;

      AST_LAST_LOADS: assert property (@(posedge clk) disable iff (rst)
        (stb && !clr) |=> (rec_q == $past(live_i))); // R4
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rec_q <= '0;
    end else if (cap_en) begin
      rec_q <= live_i;
    end
  end

  assign rec_o = rec_q;

  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> (rec_q == '0)); // R1

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clr |=> (rec_q == '0)); // R5

endmodule

// File: rtl/pts_ctrl.sv
module pts_ctrl #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 10
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              clr_o
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  // The clear bit is not stored: a write with it set yields a one-cycle pulse
  always_comb begin
    clr_o = wr_en && (addr == CTRL_A) && wdata[pts_pkg::CLR_BIT];
  end

endmodule

// File: rtl/pts_readmux.sv
module pts_readmux #(
  parameter int FIELD_W    = 8,
  parameter int NUM_FIELDS = 5,
  parameter int NUM_RECS   = 2,
  parameter int ADDR_W     = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [NUM_RECS*FIELD_W*NUM_FIELDS-1:0] recs_i,
  input  logic [ADDR_W-1:0]                      addr,
  output logic [FIELD_W-1:0]                     rdata_o
);

  localparam int                MAP_SIZE = NUM_RECS * NUM_FIELDS;
  localparam logic [ADDR_W-1:0] MAP_END  = ADDR_W'(MAP_SIZE);

  logic [FIELD_W-1:0] bytes_w [MAP_SIZE];
  logic [FIELD_W-1:0] rdata_q;

  generate
    for (genvar i = 0; i < MAP_SIZE; i++) begin : g_byte
      assign bytes_w[i] = recs_i[i*FIELD_W +: FIELD_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (addr < MAP_END) begin
      rdata_q <= bytes_w[addr];
    end else begin
      rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr >= MAP_END) |=> (rdata_q == '0)); // R9

endmodule

// File: rtl/pwr_tstamp_capture.sv
module pwr_tstamp_capture #(
  parameter int FIELD_W = 8,
  parameter int ADDR_W  = 4
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [FIELD_W-1:0]                    tm_sec,
  input  logic [FIELD_W-1:0]                    tm_min,
  input  logic [FIELD_W-1:0]                    tm_hour,
  input  logic [FIELD_W-1:0]                    tm_date,
  input  logic [FIELD_W-1:0]                    tm_month,
  input  logic                                  to_bat_stb,
  input  logic                                  to_main_stb,
  input  logic                                  reg_wr,
  input  logic [ADDR_W-1:0]                     reg_addr,
  input  logic [FIELD_W-1:0]                    reg_wdata,
  output logic [FIELD_W-1:0]                    reg_rdata,
  output logic [FIELD_W*pts_pkg::NUM_FIELDS-1:0] rec_to_bat,
  output logic [FIELD_W*pts_pkg::NUM_FIELDS-1:0] rec_to_main
);

  localparam int NUM_FIELDS = pts_pkg::NUM_FIELDS;
  localparam int NUM_RECS   = pts_pkg::NUM_RECS;
  localparam int REC_W      = FIELD_W * NUM_FIELDS;
  localparam int CTRL_ADDR  = NUM_RECS * NUM_FIELDS;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic [REC_W-1:0]          live_w;
  logic [REC_W-1:0]          rec_bat_w;
  logic [REC_W-1:0]          rec_main_w;
  logic [NUM_RECS*REC_W-1:0] recs_w;
  logic                      clr_w;

  assign live_w = {tm_month, tm_date, tm_hour, tm_min, tm_sec};
  assign recs_w = {rec_main_w, rec_bat_w};

  pts_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (FIELD_W),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_ctrl (
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .clr_o (clr_w)
  );

  pts_record #(
    .FIELD_W    (FIELD_W),
    .NUM_FIELDS (NUM_FIELDS),
    .MODE       (pts_pkg::CAP_KEEP_FIRST)
  ) u_rec_bat (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_w),
    .stb    (to_bat_stb),
    .live_i (live_w),
    .rec_o  (rec_bat_w)
  );

  pts_record #(
    .FIELD_W    (FIELD_W),
    .NUM_FIELDS (NUM_FIELDS),
    .MODE       (pts_pkg::CAP_KEEP_LAST)
  ) u_rec_main (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_w),
    .stb    (to_main_stb),
    .live_i (live_w),
    .rec_o  (rec_main_w)
  );

  pts_readmux #(
    .FIELD_W    (FIELD_W),
    .NUM_FIELDS (NUM_FIELDS),
    .NUM_RECS   (NUM_RECS),
    .ADDR_W     (ADDR_W)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .recs_i  (recs_w),
    .addr    (reg_addr),
    .rdata_o (reg_rdata)
  );

  assign rec_to_bat  = rec_bat_w;
  assign rec_to_main = rec_main_w;

  AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == CTRL_A) |=> (reg_rdata == '0)); // R8

  AST_CLEAR_BEATS_STROBE: assert property (@(posedge clk) disable iff (rst)
    (clr_w && (to_bat_stb || to_main_stb)) |=> (rec_to_bat == '0 && rec_to_main == '0)); // R7

  AST_NOOP_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == CTRL_A && !reg_wdata[pts_pkg::CLR_BIT] && !to_bat_stb && !to_main_stb)
      |=> ($stable(rec_to_bat) && $stable(rec_to_main))); // R6

endmodule

// File: tb/pwr_tstamp_capture_tb.sv
`timescale 1ns/1ps
module pwr_tstamp_capture_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  tm_sec = '0, tm_min = '0, tm_hour = '0, tm_date = '0, tm_month = '0;
  logic        to_bat_stb = 1'b0, to_main_stb = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [39:0] rec_to_bat, rec_to_main;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  pwr_tstamp_capture u_dut (
    .clk         (clk),
    .rst         (rst),
    .tm_sec      (tm_sec),
    .tm_min      (tm_min),
    .tm_hour     (tm_hour),
    .tm_date     (tm_date),
    .tm_month    (tm_month),
    .to_bat_stb  (to_bat_stb),
    .to_main_stb (to_main_stb),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .rec_to_bat  (rec_to_bat),
    .rec_to_main (rec_to_main)
  );

  task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // packed form: month,date,hour,min,sec
  task automatic set_time(input logic [39:0] t);
    {tm_month, tm_date, tm_hour, tm_min, tm_sec} = t;
  endtask

  task automatic pulse(input bit bat, input bit mains);
    @(negedge clk);
    to_bat_stb  = bat;
    to_main_stb = mains;
    @(negedge clk);
    to_bat_stb  = 1'b0;
    to_main_stb = 1'b0;
  endtask

  task automatic write_ctrl(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd10; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic read_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 d = reg_rdata;
  endtask

  task automatic read_rec(input int base, output logic [39:0] r);
    logic [7:0] b;
    for (int i = 0; i < 5; i++) begin
      read_reg(4'(base + i), b);
      r[i*8 +: 8] = b;
    end
  endtask

  task automatic t_reset;
    logic [39:0] r;
    logic [7:0]  b;
    check("R1 rec_to_bat after reset", rec_to_bat, '0);
    check("R1 rec_to_main after reset", rec_to_main, '0);
    check("R1 rdata after reset", {32'h0, reg_rdata}, '0);
    read_rec(0, r); check("R1 read bat bytes", r, '0);
    read_rec(5, r); check("R1 read main bytes", r, '0);
    read_reg(4'd10, b); check("R1 read ctrl", {32'h0, b}, '0);
  endtask

  task automatic t_first_capture;
    logic [39:0] r;
    set_time(40'h01_01_11_30_59);
    pulse(1'b1, 1'b0);
    check("R2 bat captured", rec_to_bat, 40'h01_01_11_30_59);
    check("R2 main untouched", rec_to_main, '0);
    read_rec(0, r); check("R9 bat via reads", r, 40'h01_01_11_30_59);
  endtask

  task automatic t_hold_first;
    set_time(40'h12_31_23_59_58);
    pulse(1'b1, 1'b0);
    check("R3 bat frozen on second event", rec_to_bat, 40'h01_01_11_30_59);
    set_time(40'h06_15_07_07_07);
    pulse(1'b1, 1'b0);
    check("R3 bat frozen on third event", rec_to_bat, 40'h01_01_11_30_59);
  endtask

  task automatic t_last_overwrite;
    logic [39:0] r;
    set_time(40'h03_04_05_06_07);
    pulse(1'b0, 1'b1);
    check("R4 main first load", rec_to_main, 40'h03_04_05_06_07);
    set_time(40'h09_28_22_45_12);
    pulse(1'b0, 1'b1);
    check("R4 main overwritten", rec_to_main, 40'h09_28_22_45_12);
    read_rec(5, r); check("R9 main via reads", r, 40'h09_28_22_45_12);
  endtask

  task automatic t_clear_noop;
    write_ctrl(8'hFE);
    check("R6 bat kept", rec_to_bat, 40'h01_01_11_30_59);
    check("R6 main kept", rec_to_main, 40'h09_28_22_45_12);
  endtask

  task automatic t_ctrl_and_unmapped;
    logic [7:0] b;
    read_reg(4'd10, b); check("R8 ctrl reads zero", {32'h0, b}, '0);
    read_reg(4'd11, b); check("R9 addr 11 zero", {32'h0, b}, '0);
    read_reg(4'd15, b); check("R9 addr 15 zero", {32'h0, b}, '0);
    read_reg(4'd2, b);  check("R9 addr 2 hours", {32'h0, b}, 40'h11);
    read_reg(4'd9, b);  check("R9 addr 9 month", {32'h0, b}, 40'h09);
  endtask

  task automatic t_clear;
    logic [7:0] b;
    write_ctrl(8'h01);
    check("R5 bat cleared", rec_to_bat, '0);
    check("R5 main cleared", rec_to_main, '0);
    read_reg(4'd10, b); check("R8 ctrl zero after clear", {32'h0, b}, '0);
    set_time(40'h02_14_08_15_33);
    pulse(1'b1, 1'b0);
    check("R5 bat re-armed", rec_to_bat, 40'h02_14_08_15_33);
  endtask

  task automatic t_clear_vs_strobe;
    set_time(40'h07_07_07_07_07);
    pulse(1'b0, 1'b1);
    @(negedge clk);
    set_time(40'h05_05_05_05_05);
    reg_wr = 1'b1; reg_addr = 4'd10; reg_wdata = 8'h01;
    to_bat_stb = 1'b1; to_main_stb = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    to_bat_stb = 1'b0; to_main_stb = 1'b0;
    check("R7 bat zero on collision", rec_to_bat, '0);
    check("R7 main zero on collision", rec_to_main, '0);
    set_time(40'h08_20_16_40_01);
    pulse(1'b1, 1'b0);
    check("R7 bat armed after collision", rec_to_bat, 40'h08_20_16_40_01);
  endtask

  task automatic t_both_strobes;
    write_ctrl(8'h81);
    set_time(40'h11_30_10_20_30);
    pulse(1'b1, 1'b1);
    check("R10 bat on joint strobe", rec_to_bat, 40'h11_30_10_20_30);
    check("R10 main on joint strobe", rec_to_main, 40'h11_30_10_20_30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_capture();
    t_hold_first();
    t_last_overwrite();
    t_clear_noop();
    t_ctrl_and_unmapped();
    t_clear();
    t_clear_vs_strobe();
    t_both_strobes();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule